// File: doc/BRIEF.md
# Memory Error Trap Controller

This block takes error events reported by the memory system and decides which processor trap, if any, each one raises. Each event arrives on one of `NUM_SRC` parallel source channels as a valid strobe, an error class and the operation that caused it. The trap depends on both. A bus failure seen on an instruction fetch raises the precise instruction-access trap. The same failure on a load or atomic raises the precise data-access trap. On a store merge, writeback, copyout, vector fetch or plain bus read it raises the disrupting trap. Cache-array errors only trap on local reads. Hardware-corrected errors trap as disrupting from any operation.

A software-written control register holds three trap enables and two forcing controls. The forcing controls substitute fixed check bits for the generated data and tag check bits on the write path. A sticky status register records the class of every event whether or not its trap is enabled. Software clears it by writing ones. When a precise and a disrupting trap fall due in the same cycle, the precise one is issued first and the disrupting one follows a cycle later.

Top module: `mem_err_trap_ctrl`

## Requirements
- R1: The control register reads back on `ctrl_o` what was last written on `ctrl_wdata_i`, with these fields: bit 0 corrected-error trap enable, bit 1 uncorrectable/bus-failure trap enable, bit 3 cache fast-error trap enable, bits 12:4 forced data check value, bit 13 data force enable, bits 17:14 forced tag check value, bit 18 tag force enable. Bit 2 always reads 0. Reset value is all zeros. A write takes effect in the cycle after the strobe.
- R2: The error class is 3 bits: 0 cache correctable, 1 cache uncorrectable, 2 bus data uncorrectable, 3 bus tag uncorrectable, 4 bus timeout, 5 bus error, 6 hardware-corrected data, 7 hardware-corrected tag. The operation is 3 bits: 0 instruction fetch, 1 load, 2 atomic, 3 store merge, 4 writeback, 5 copyout, 6 interrupt vector fetch, 7 bus read. A class 0 or 1 event from operation 0, 1 or 2 raises `trap_fast_o` when bit 3 is set. The pulse lasts one cycle and comes in the cycle after the event is sampled.
- R3: A class 0 or 1 event from operation 3, 4, 5, 6 or 7 raises no trap.
- R4: When bit 1 is set, an event of class 2 to 5 raises `trap_iacc_o` for operation 0, and `trap_dacc_o` for operation 1 or 2.
- R5: When bit 1 is set, an event of class 2 to 5 from operation 3, 4, 5, 6 or 7 raises `trap_disr_o`.
- R6: When bit 0 is set, an event of class 6 or 7 raises `trap_disr_o` for every operation.
- R7: Each valid event sets bit `class` of `status_o` in the cycle after it is sampled, whatever the enables hold.
- R8: Status bits stay set until a one is written to that bit position through `sts_w1c_i`. If a clear and a new event hit the same bit in one cycle, the bit stays set.
- R9: A disrupting trap never pulses in the same cycle as a precise trap (`trap_fast_o`, `trap_iacc_o`, `trap_dacc_o`). A disrupting request that meets a precise one is held pending and issued in the first cycle with no precise trap. Pending and new disrupting requests merge into one pulse.
- R10: When bit 13 is set, `data_chk_o` carries bits 12:4. Otherwise it passes `data_chk_i` through.
- R11: When bit 18 is set, `tag_chk_o` carries bits 17:14. Otherwise it passes `tag_chk_i` through.
- R12: When the matching enable bit is clear, no trap is raised for an event; its status bit is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 19 | Control register write data |
| ctrl_o | output | 19 | Control register contents |
| evt_valid_i | input | NUM_SRC | Per-source event strobe |
| evt_class_i | input | 3*NUM_SRC | Per-source error class |
| evt_op_i | input | 3*NUM_SRC | Per-source originating operation |
| sts_w1c_i | input | 8 | Write-one-to-clear mask for status |
| status_o | output | 8 | Sticky status, one bit per class |
| data_chk_i | input | 9 | Generated data check bits |
| tag_chk_i | input | 4 | Generated tag check bits |
| data_chk_o | output | 9 | Data check bits to storage |
| tag_chk_o | output | 4 | Tag check bits to storage |
| trap_fast_o | output | 1 | Fast cache-error trap pulse |
| trap_iacc_o | output | 1 | Instruction-access-error trap pulse |
| trap_dacc_o | output | 1 | Data-access-error trap pulse |
| trap_disr_o | output | 1 | Disrupting error trap pulse |

## Verification
Several properties are checked on every cycle:
- the disrupting pulse never overlaps a precise pulse;
- no precise trap fires unless its enable was set;
- a status bit drops only under a matching clear, and every sampled event leaves its class bit set;
- the check-bit outputs follow the force fields;
- the reserved bit stays zero.

Only the bench scenarios show that the class and operation pair picks the right trap among the four. They also show that a deferred disrupting trap appears exactly one cycle after its precise partner, that back-to-back collisions keep it pending, and that a clear coinciding with a new event loses.

// File: rtl/err_trap_pkg.sv
package err_trap_pkg;
  localparam int NCLS   = 8;
  localparam int CLS_W  = 3;
  localparam int OP_W   = 3;
  localparam int DCHK_W = 9;
  localparam int TCHK_W = 4;

  // control field positions
  localparam int BIT_CE_EN   = 0;
  localparam int BIT_UE_EN   = 1;
  localparam int BIT_RSVD    = 2;
  localparam int BIT_FAST_EN = 3;
  localparam int DCHK_LSB    = 4;
  localparam int BIT_DFRC    = DCHK_LSB + DCHK_W;
  localparam int TCHK_LSB    = BIT_DFRC + 1;
  localparam int BIT_TFRC    = TCHK_LSB + TCHK_W;
  localparam int CTRL_W      = BIT_TFRC + 1;

  typedef enum logic [CLS_W-1:0] {
    CLS_CACHE_CE, CLS_CACHE_UE, CLS_BUS_DUE, CLS_BUS_TUE,
    CLS_BUS_TO,   CLS_BUS_ERR,  CLS_HW_CD,   CLS_HW_CT
  } err_cls_e;

  typedef enum logic [OP_W-1:0] {
    OP_FETCH, OP_LOAD, OP_ATOMIC, OP_MERGE,
    OP_WBACK, OP_COPYOUT, OP_IVEC, OP_BUSRD
  } err_op_e;

  typedef struct packed {
    logic disr;
    logic dacc;
    logic iacc;
    logic fast;
  } trap_req_t;
endpackage

// File: rtl/err_classify.sv
module err_classify
  import err_trap_pkg::*;
(
  input  logic            valid_i,
  input  err_cls_e        cls_i,
  input  err_op_e         op_i,
  input  logic            en_fast_i,
  input  logic            en_ue_i,
  input  logic            en_ce_i,
  output trap_req_t       req_o,
  output logic [NCLS-1:0] set_o
);
  always_comb begin
    req_o = '0;
    set_o = '0;
    set_o[cls_i] = valid_i;
    if (valid_i) begin
      unique case (cls_i)
        CLS_CACHE_CE, CLS_CACHE_UE: begin
          // only local reads of the cache array trap
          if (en_fast_i && (op_i inside {OP_FETCH, OP_LOAD, OP_ATOMIC})) req_o.fast = 1'b1;
        end
        CLS_BUS_DUE, CLS_BUS_TUE, CLS_BUS_TO, CLS_BUS_ERR: begin
          if (en_ue_i) begin
            unique case (op_i)
              OP_FETCH:          req_o.iacc = 1'b1;
              OP_LOAD, OP_ATOMIC: req_o.dacc = 1'b1;
              default:           req_o.disr = 1'b1;
            endcase
          end
        end
        default: begin
          if (en_ce_i) req_o.disr = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/err_trap_arb.sv
module err_trap_arb
  import err_trap_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  trap_req_t [NUM_SRC-1:0]  req_i,
  output trap_req_t                trap_o
);
  logic [3:0] any_w;
  trap_req_t  any_r;
  logic       precise_w, disr_want_w, pend_q;
  trap_req_t  trap_q;

  always_comb begin
    any_w = '0;
    for (int i = 0; i < NUM_SRC; i++) any_w = any_w | req_i[i];
  end

  assign any_r       = trap_req_t'(any_w);
  assign precise_w   = any_r.fast | any_r.iacc | any_r.dacc;
  assign disr_want_w = any_r.disr | pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_q <= '0;
      pend_q <= 1'b0;
    end else begin
      trap_q.fast <= any_r.fast;
      trap_q.iacc <= any_r.iacc;
      trap_q.dacc <= any_r.dacc;
      trap_q.disr <= disr_want_w & ~precise_w;
      pend_q      <= disr_want_w & precise_w;
    end
  end

  assign trap_o = trap_q;
endmodule

// File: rtl/err_status_reg.sv
module err_status_reg
  import err_trap_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCLS-1:0] set_i,
  input  logic [NCLS-1:0] w1c_i,
  output logic [NCLS-1:0] sts_o
);
  logic [NCLS-1:0] sts_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~w1c_i) | set_i;
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/err_ctrl_reg.sv
module err_ctrl_reg
  import err_trap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic [DCHK_W-1:0] data_chk_i,
  input  logic [TCHK_W-1:0] tag_chk_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              en_ce_o,
  output logic              en_ue_o,
  output logic              en_fast_o,
  output logic [DCHK_W-1:0] data_chk_o,
  output logic [TCHK_W-1:0] tag_chk_o
);
  localparam logic [CTRL_W-1:0] WMASK = ~(CTRL_W'(1) << BIT_RSVD);

  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (we_i) ctrl_q <= wdata_i & WMASK;
  end

  assign ctrl_o     = ctrl_q;
  assign en_ce_o    = ctrl_q[BIT_CE_EN];
  assign en_ue_o    = ctrl_q[BIT_UE_EN];
  assign en_fast_o  = ctrl_q[BIT_FAST_EN];
  assign data_chk_o = ctrl_q[BIT_DFRC] ? ctrl_q[DCHK_LSB +: DCHK_W] : data_chk_i;
  assign tag_chk_o  = ctrl_q[BIT_TFRC] ? ctrl_q[TCHK_LSB +: TCHK_W] : tag_chk_i;
endmodule

// File: rtl/mem_err_trap_ctrl.sv
module mem_err_trap_ctrl
  import err_trap_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ctrl_we_i,
  input  logic [CTRL_W-1:0]        ctrl_wdata_i,
  output logic [CTRL_W-1:0]        ctrl_o,
  input  logic [NUM_SRC-1:0]       evt_valid_i,
  input  logic [NUM_SRC*CLS_W-1:0] evt_class_i,
  input  logic [NUM_SRC*OP_W-1:0]  evt_op_i,
  input  logic [NCLS-1:0]          sts_w1c_i,
  output logic [NCLS-1:0]          status_o,
  input  logic [DCHK_W-1:0]        data_chk_i,
  input  logic [TCHK_W-1:0]        tag_chk_i,
  output logic [DCHK_W-1:0]        data_chk_o,
  output logic [TCHK_W-1:0]        tag_chk_o,
  output logic                     trap_fast_o,
  output logic                     trap_iacc_o,
  output logic                     trap_dacc_o,
  output logic                     trap_disr_o
);
  logic en_ce, en_ue, en_fast;
  trap_req_t [NUM_SRC-1:0] req_w;
  logic [NUM_SRC-1:0][NCLS-1:0] set_w;
  logic [NCLS-1:0] set_any;
  trap_req_t trap_w;

  err_ctrl_reg i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (ctrl_we_i),
    .wdata_i    (ctrl_wdata_i),
    .data_chk_i (data_chk_i),
    .tag_chk_i  (tag_chk_i),
    .ctrl_o     (ctrl_o),
    .en_ce_o    (en_ce),
    .en_ue_o    (en_ue),
    .en_fast_o  (en_fast),
    .data_chk_o (data_chk_o),
    .tag_chk_o  (tag_chk_o)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    err_classify i_cls (
      .valid_i   (evt_valid_i[g]),
      .cls_i     (err_cls_e'(evt_class_i[g*CLS_W +: CLS_W])),
      .op_i      (err_op_e'(evt_op_i[g*OP_W +: OP_W])),
      .en_fast_i (en_fast),
      .en_ue_i   (en_ue),
      .en_ce_i   (en_ce),
      .req_o     (req_w[g]),
      .set_o     (set_w[g])
    );
  end

  always_comb begin
    set_any = '0;
    for (int i = 0; i < NUM_SRC; i++) set_any = set_any | set_w[i];
  end

  err_status_reg i_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_any),
    .w1c_i  (sts_w1c_i),
    .sts_o  (status_o)
  );

  err_trap_arb #(.NUM_SRC(NUM_SRC)) i_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_w),
    .trap_o (trap_w)
  );

  assign trap_fast_o = trap_w.fast;
  assign trap_iacc_o = trap_w.iacc;
  assign trap_dacc_o = trap_w.dacc;
  assign trap_disr_o = trap_w.disr;
endmodule

// File: rtl/err_trap_chk.sv
module err_trap_chk
  import err_trap_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [CTRL_W-1:0]        ctrl_o,
  input logic [NUM_SRC-1:0]       evt_valid_i,
  input logic [NUM_SRC*CLS_W-1:0] evt_class_i,
  input logic [NCLS-1:0]          sts_w1c_i,
  input logic [NCLS-1:0]          status_o,
  input logic [DCHK_W-1:0]        data_chk_i,
  input logic [TCHK_W-1:0]        tag_chk_i,
  input logic [DCHK_W-1:0]        data_chk_o,
  input logic [TCHK_W-1:0]        tag_chk_o,
  input logic                     trap_fast_o,
  input logic                     trap_iacc_o,
  input logic                     trap_dacc_o,
  input logic                     trap_disr_o
);
  assert_rsvd_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[BIT_RSVD] == 1'b0);

  assert_no_overlap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_disr_o |-> !(trap_fast_o || trap_iacc_o || trap_dacc_o));

  assert_fast_gated_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_fast_o |-> $past(ctrl_o[BIT_FAST_EN]));

  assert_iacc_gated_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_iacc_o |-> $past(ctrl_o[BIT_UE_EN]));

  assert_dacc_gated_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_dacc_o |-> $past(ctrl_o[BIT_UE_EN]));

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & $past(status_o) & ~$past(sts_w1c_i)) == ($past(status_o) & ~$past(sts_w1c_i)));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_evt
    assert_status_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_valid_i[g] |=> status_o[$past(evt_class_i[g*CLS_W +: CLS_W])]);
  end

  assert_data_force_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_chk_o == (ctrl_o[BIT_DFRC] ? ctrl_o[DCHK_LSB +: DCHK_W] : data_chk_i));

  assert_tag_force_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_chk_o == (ctrl_o[BIT_TFRC] ? ctrl_o[TCHK_LSB +: TCHK_W] : tag_chk_i));
endmodule

bind mem_err_trap_ctrl err_trap_chk #(.NUM_SRC(NUM_SRC)) i_err_trap_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_o      (ctrl_o),
  .evt_valid_i (evt_valid_i),
  .evt_class_i (evt_class_i),
  .sts_w1c_i   (sts_w1c_i),
  .status_o    (status_o),
  .data_chk_i  (data_chk_i),
  .tag_chk_i   (tag_chk_i),
  .data_chk_o  (data_chk_o),
  .tag_chk_o   (tag_chk_o),
  .trap_fast_o (trap_fast_o),
  .trap_iacc_o (trap_iacc_o),
  .trap_dacc_o (trap_dacc_o),
  .trap_disr_o (trap_disr_o)
);

// File: tb/test_mem_err_trap_ctrl.sv
module test_mem_err_trap_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ctrl_we_i = 1'b0;
  logic [18:0] ctrl_wdata_i = '0;
  logic [18:0] ctrl_o;
  logic [NS-1:0] evt_valid_i = '0;
  logic [NS*3-1:0] evt_class_i = '0;
  logic [NS*3-1:0] evt_op_i = '0;
  logic [7:0] sts_w1c_i = '0;
  logic [7:0] status_o;
  logic [8:0] data_chk_i = '0;
  logic [3:0] tag_chk_i = '0;
  logic [8:0] data_chk_o;
  logic [3:0] tag_chk_o;
  logic trap_fast_o, trap_iacc_o, trap_dacc_o, trap_disr_o;

  mem_err_trap_ctrl #(.NUM_SRC(NS)) i_mem_err_trap_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i),
    .ctrl_o(ctrl_o), .evt_valid_i(evt_valid_i), .evt_class_i(evt_class_i),
    .evt_op_i(evt_op_i), .sts_w1c_i(sts_w1c_i), .status_o(status_o),
    .data_chk_i(data_chk_i), .tag_chk_i(tag_chk_i), .data_chk_o(data_chk_o),
    .tag_chk_o(tag_chk_o), .trap_fast_o(trap_fast_o), .trap_iacc_o(trap_iacc_o),
    .trap_dacc_o(trap_dacc_o), .trap_disr_o(trap_disr_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct packed {
    logic [3:0]  trap;   // {disr, dacc, iacc, fast}
    logic [7:0]  sts;
    logic [18:0] ctrl;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int n_run = 0;
  int n_fail = 0;
  int seed = 0;
  logic [18:0] m_ctrl = '0;
  logic [7:0]  m_sts = '0;
  logic        m_pend = 1'b0;

  function automatic logic [3:0] ref_req(input logic [2:0] c, input logic [2:0] o,
                                         input logic [18:0] cr);
    if (c <= 3'd1) return (cr[3] && o <= 3'd2) ? 4'b0001 : 4'b0000;
    if (c <= 3'd5) begin
      if (!cr[1]) return 4'b0000;
      if (o == 3'd0) return 4'b0010;
      if (o == 3'd1 || o == 3'd2) return 4'b0100;
      return 4'b1000;
    end
    return cr[0] ? 4'b1000 : 4'b0000;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v0, input logic [2:0] c0, input logic [2:0] o0,
                      input logic v1, input logic [2:0] c1, input logic [2:0] o1,
                      input logic [7:0] w1c, input logic we, input logic [18:0] wd,
                      input string tag);
    logic [3:0] r;
    logic precise, dw;
    logic [18:0] oc;
    @(negedge clk_i);
    evt_valid_i = {v1, v0};
    evt_class_i = {c1, c0};
    evt_op_i    = {o1, o0};
    sts_w1c_i   = w1c;
    ctrl_we_i   = we;
    ctrl_wdata_i = wd;
    data_chk_i  = 9'(seed * 37 + 5);
    tag_chk_i   = 4'(seed * 3 + 1);
    seed++;
    oc = m_ctrl;
    r = (v0 ? ref_req(c0, o0, m_ctrl) : 4'b0) | (v1 ? ref_req(c1, o1, m_ctrl) : 4'b0);
    precise = |r[2:0];
    dw = r[3] | m_pend;
    m_pend = dw & precise;
    m_sts = (m_sts & ~w1c) | (v0 ? 8'(1) << c0 : 8'h0) | (v1 ? 8'(1) << c1 : 8'h0);
    if (we) m_ctrl = wd & 19'h7FFFB;
    exp_q.push_back('{trap: {dw & ~precise, r[2:0]}, sts: m_sts, ctrl: m_ctrl});
    tag_q.push_back(tag);
    #1;
    check("R10", "data_chk_o", 32'(data_chk_o), 32'(oc[13] ? oc[12:4] : data_chk_i));
    check("R11", "tag_chk_o", 32'(tag_chk_o), 32'(oc[18] ? oc[17:14] : tag_chk_i));
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 8'h0, 0, '0, tag);
  endtask
  task automatic ev(input logic [2:0] c, input logic [2:0] o, input string tag);
    step(1, c, o, 0, 0, 0, 8'h0, 0, '0, tag);
  endtask
  task automatic wr(input logic [18:0] v, input string tag);
    step(0, 0, 0, 0, 0, 0, 8'h0, 1, v, tag);
  endtask

  // monitor: compare the scoreboard head after each edge
  always @(posedge clk_i) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, "traps", 32'({trap_disr_o, trap_dacc_o, trap_iacc_o, trap_fast_o}), 32'(e.trap));
      check(t, "status_o", 32'(status_o), 32'(e.sts));
      check(t, "ctrl_o", 32'(ctrl_o), 32'(e.ctrl));
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog R1 run: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check("R1", "reset ctrl_o", 32'(ctrl_o), 32'h0);
    check("R7", "reset status_o", 32'(status_o), 32'h0);
    check("R9", "reset traps", 32'({trap_disr_o, trap_dacc_o, trap_iacc_o, trap_fast_o}), 32'h0);

    wr(19'h0000B, "R1 enables");
    // R2 local reads of cache array
    ev(3'd0, 3'd1, "R2 ce load");
    ev(3'd1, 3'd0, "R2 ue fetch");
    ev(3'd0, 3'd2, "R2 ce atomic");
    // R3 other operations
    for (int o = 3; o < 8; o++) ev(3'd1, 3'(o), "R3 cache other op");
    // R4 precise access traps
    ev(3'd2, 3'd0, "R4 bus data ue fetch");
    ev(3'd3, 3'd0, "R4 bus tag ue fetch");
    ev(3'd4, 3'd1, "R4 timeout load");
    ev(3'd5, 3'd2, "R4 bus err atomic");
    // R5 disrupting for non-local operations
    ev(3'd5, 3'd3, "R5 bus err merge");
    idle("R5 gap");
    ev(3'd4, 3'd4, "R5 timeout writeback");
    ev(3'd2, 3'd5, "R5 data ue copyout");
    ev(3'd3, 3'd6, "R5 tag ue vector fetch");
    ev(3'd2, 3'd7, "R5 data ue bus read");
    // R6 corrected errors from any op
    for (int o = 0; o < 8; o++) ev(3'(6 + (o & 1)), 3'(o), "R6 hw corrected");
    // R9 collisions
    idle("R9 gap");
    step(1, 3'd0, 3'd1, 1, 3'd6, 3'd3, 8'h0, 0, '0, "R9 fast plus disr");
    idle("R9 deferred disr");
    step(1, 3'd2, 3'd0, 1, 3'd5, 3'd4, 8'h0, 0, '0, "R9 iacc plus disr");
    step(1, 3'd4, 3'd1, 0, 3'd0, 3'd0, 8'h0, 0, '0, "R9 pending held");
    step(0, 3'd0, 3'd0, 1, 3'd7, 3'd5, 8'h0, 0, '0, "R9 merged disr");
    idle("R9 drain");
    // R8 write-one-to-clear
    step(0, 0, 0, 0, 0, 0, 8'h0F, 0, '0, "R8 clear low nibble");
    step(1, 3'd6, 3'd1, 0, 0, 0, 8'hC0, 0, '0, "R8 clear and set same bit");
    step(0, 0, 0, 0, 0, 0, 8'hFF, 0, '0, "R8 clear all");
    // R12 enables off
    wr(19'h00000, "R12 disable all");
    ev(3'd0, 3'd1, "R12 fast off");
    ev(3'd2, 3'd0, "R12 ue off fetch");
    ev(3'd5, 3'd4, "R12 ue off writeback");
    ev(3'd7, 3'd3, "R12 ce off");
    wr(19'h00001, "R12 ce only");
    ev(3'd1, 3'd2, "R12 fast still off");
    ev(3'd4, 3'd1, "R12 ue still off");
    ev(3'd6, 3'd7, "R12 ce on");
    // R10 R11 forcing; R1 reserved bit dropped
    wr(19'h40000 | (19'hA << 14) | 19'h02000 | (19'h1A5 << 4) | 19'h4, "R1 force write");
    idle("R10 forced data");
    idle("R11 forced tag");
    wr(19'h02000 | (19'h07C << 4), "R10 data only");
    idle("R11 tag pass");
    wr(19'h40000 | (19'h5 << 14), "R11 tag only");
    idle("R10 data pass");
    idle("end");
    repeat (2) @(negedge clk_i);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule